// File: doc/BRIEF.md
# Arithmetic Right Shift Execution Unit

This unit executes one fixed-point instruction: a 32-bit signed (algebraic) right shift whose amount comes from a second register. It takes the raw instruction word and the two operand values that the register file read for it. It returns the destination index, the shifted result, a carry flag, and, for the recording form, a 4-bit condition field. Any other instruction word is flagged illegal and nothing is written.

The datapath rotates the source word left by 32 minus the shift amount. It then uses a mask to choose, bit by bit, between the rotated word and a word filled with the source sign bit. The sixth bit of the amount forces the mask to zero, so any amount of 32 or more saturates to all sign bits. The outputs pass through a register stage that a parameter can remove.

Top module: `arsh_unit`

## Requirements
- R1: The word is legal only when instr_i[31:26] equals 31 and instr_i[10:1] equals 792. For a legal word, dest_idx_o equals instr_i[20:16] and result_we_o and carry_we_o are 1.
- R2: For any other word, illegal_o is 1. result_we_o, carry_we_o and cond_we_o are 0, and result_o, carry_o and cond_o are zero.
- R3: When amt_i[5] is 0, result_o is src_i shifted right arithmetically by amt_i[4:0].
- R4: When amt_i[5] is 1, result_o is 32 copies of src_i[31], and carry_o equals src_i[31].
- R5: carry_o is 1 only when src_i is negative and at least one 1 bit is shifted out.
- R6: A zero amount (amt_i[5:0] = 0) passes src_i through unchanged, with carry_o = 0.
- R7: cond_we_o equals the record bit instr_i[0]. cond_o is {LT, GT, EQ, SO} from bit 3 down to bit 0. LT, GT and EQ come from a signed comparison of result_o with zero, and SO copies so_i.
- R8: amt_i[31:6] has no effect on any output.
- R9: With OUT_REG = 1, outputs follow the inputs one clock later. A synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Raw instruction word |
| src_i | input | 32 | Value of the source register |
| amt_i | input | 32 | Value of the shift-amount register |
| so_i | input | 1 | Current summary-overflow flag |
| illegal_o | output | 1 | Instruction not recognised |
| dest_idx_o | output | 5 | Destination register index |
| result_o | output | 32 | Shifted result |
| result_we_o | output | 1 | Result write enable |
| carry_o | output | 1 | Carry value |
| carry_we_o | output | 1 | Carry write enable |
| cond_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cond_we_o | output | 1 | Condition field write enable |

## Verification
The assertions assume that every input is stable and known at each capturing edge. They also assume the register stage is present whenever a check compares an output with the previous cycle's amount or source. The bench changes inputs only on the falling edge, keeps OUT_REG at its default, and samples each result one edge after it drives it. The sweep covers all 64 values of the amount's low six bits, for positive and negative operands, with the upper amount bits held at zero and varied only in a separate test.

// File: rtl/arsh_pkg.sv
package arsh_pkg;

    localparam int XLEN  = 32;
    localparam int AMW   = $clog2(XLEN);
    localparam int SATW  = AMW + 1;
    localparam int IDXW  = 5;
    localparam int CNDW  = 4;

    localparam logic [5:0] PRIMARY_OP = 6'd31;
    localparam logic [9:0] EXTENDED_OP = 10'd792;

    typedef struct packed {
        logic            legal;
        logic            record;
        logic [IDXW-1:0] dst;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            carry;
    } shres_t;

    typedef struct packed {
        logic            illegal;
        logic [IDXW-1:0] dst;
        logic [XLEN-1:0] result;
        logic            res_we;
        logic            carry;
        logic            carry_we;
        logic [CNDW-1:0] cond;
        logic            cond_we;
    } out_t;

    function automatic logic [XLEN-1:0] rot_left(input logic [XLEN-1:0] v,
                                                 input logic [AMW-1:0]  n);
        logic [2*XLEN-1:0] w;
        w = {v, v} << n;
        return w[2*XLEN-1:XLEN];
    endfunction

endpackage

// File: rtl/arsh_decode.sv
module arsh_decode
    import arsh_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output dec_t            dec_o
);
    logic [5:0] prim;
    logic [9:0] ext;

    assign prim = instr_i[31:26];
    assign ext  = instr_i[10:1];

    always_comb begin
        dec_o.legal  = (prim == PRIMARY_OP) && (ext == EXTENDED_OP);
        dec_o.record = instr_i[0];
        dec_o.dst    = instr_i[20:16];
    end
endmodule

// File: rtl/arsh_datapath.sv
module arsh_datapath
    import arsh_pkg::*;
(
    input  logic [XLEN-1:0] src_i,
    input  logic [SATW-1:0] amt_i,
    output shres_t          res_o
);
    logic [AMW-1:0]  n;
    logic [AMW-1:0]  lsh;
    logic [XLEN-1:0] rotated;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] signw;

    assign n       = amt_i[AMW-1:0];
    assign lsh     = AMW'(XLEN - int'(n));
    assign rotated = rot_left(src_i, lsh);
    assign mask    = amt_i[SATW-1] ? '0 : ({XLEN{1'b1}} >> n);
    assign signw   = {XLEN{src_i[XLEN-1]}};

    always_comb begin
        res_o.value = (rotated & mask) | (signw & ~mask);
        res_o.carry = src_i[XLEN-1] & (|(rotated & ~mask));
    end
endmodule

// File: rtl/arsh_flags.sv
module arsh_flags
    import arsh_pkg::*;
(
    input  logic [XLEN-1:0] value_i,
    input  logic            so_i,
    output logic [CNDW-1:0] cond_o
);
    logic neg, zero;

    assign neg  = value_i[XLEN-1];
    assign zero = (value_i == '0);

    always_comb begin
        cond_o[3] = neg;
        cond_o[2] = ~neg & ~zero;
        cond_o[1] = zero;
        cond_o[0] = so_i;
    end
endmodule

// File: rtl/arsh_unit.sv
module arsh_unit
    import arsh_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] amt_i,
    input  logic            so_i,
    output logic            illegal_o,
    output logic [IDXW-1:0] dest_idx_o,
    output logic [XLEN-1:0] result_o,
    output logic            result_we_o,
    output logic            carry_o,
    output logic            carry_we_o,
    output logic [CNDW-1:0] cond_o,
    output logic            cond_we_o
);
    dec_t            dec;
    shres_t          sh;
    logic [CNDW-1:0] cond;
    out_t            nxt;
    out_t            cur;
    logic            unused_bits;

    assign unused_bits = ^{amt_i[XLEN-1:SATW], instr_i[25:21], instr_i[15:11]};

    arsh_decode   u_dec  (.instr_i(instr_i), .dec_o(dec));
    arsh_datapath u_dp   (.src_i(src_i), .amt_i(amt_i[SATW-1:0]), .res_o(sh));
    arsh_flags    u_flg  (.value_i(sh.value), .so_i(so_i), .cond_o(cond));

    always_comb begin
        nxt          = '0;
        nxt.illegal  = ~dec.legal;
        if (dec.legal) begin
            nxt.dst      = dec.dst;
            nxt.result   = sh.value;
            nxt.res_we   = 1'b1;
            nxt.carry    = sh.carry;
            nxt.carry_we = 1'b1;
            nxt.cond     = dec.record ? cond : '0;
            nxt.cond_we  = dec.record;
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) cur <= '0;
                else     cur <= nxt;
            end

            // R6: zero amount passes the source through
            a_r6_zero_pass: assert property (@(posedge clk) disable iff (rst)
                (result_we_o && $past(amt_i[SATW-1:0]) == '0)
                    |-> (result_o == $past(src_i) && !carry_o));
            // R4: saturated amount yields sign fill
            a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
                (result_we_o && $past(amt_i[SATW-1]))
                    |-> (result_o == {XLEN{$past(src_i[XLEN-1])}}));
            // R7: SO copied from flag
            a_r7_so_copy: assert property (@(posedge clk) disable iff (rst)
                cond_we_o |-> (cond_o[0] == $past(so_i)));
        end else begin : g_comb
            assign cur = nxt;
        end
    endgenerate

    assign illegal_o   = cur.illegal;
    assign dest_idx_o  = cur.dst;
    assign result_o    = cur.result;
    assign result_we_o = cur.res_we;
    assign carry_o     = cur.carry;
    assign carry_we_o  = cur.carry_we;
    assign cond_o      = cur.cond;
    assign cond_we_o   = cur.cond_we;

    // R2: illegal suppresses all writes
    a_r2_no_write: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!result_we_o && !carry_we_o && !cond_we_o));
    // R7: exactly one of LT/GT/EQ when written
    a_r7_one_rel: assert property (@(posedge clk) disable iff (rst)
        cond_we_o |-> $onehot(cond_o[3:1]));
    // R7: EQ agrees with result
    a_r7_eq_zero: assert property (@(posedge clk) disable iff (rst)
        cond_we_o |-> (cond_o[1] == (result_o == '0)));
    // R5: carry only for a negative operand, whose result stays negative
    a_r5_carry_neg: assert property (@(posedge clk) disable iff (rst)
        carry_o |-> result_o[XLEN-1]);
    // R1: legal words write result and carry together
    a_r1_we_pair: assert property (@(posedge clk) disable iff (rst)
        result_we_o == carry_we_o);
endmodule

// File: tb/sim_arsh_unit.sv
module sim_arsh_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic [31:0] src = '0;
    logic [31:0] amt = '0;
    logic        so = 1'b0;
    logic        illegal, res_we, carry, carry_we, cond_we;
    logic [4:0]  dst;
    logic [31:0] result;
    logic [3:0]  cond;
    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    arsh_unit u0 (
        .clk(clk), .rst(rst), .instr_i(instr), .src_i(src), .amt_i(amt), .so_i(so),
        .illegal_o(illegal), .dest_idx_o(dst), .result_o(result), .result_we_o(res_we),
        .carry_o(carry), .carry_we_o(carry_we), .cond_o(cond), .cond_we_o(cond_we)
    );

    function automatic logic [31:0] mk_instr(input logic [4:0] rd, input logic rec);
        return {6'd31, 5'd3, rd, 5'd7, 10'd792, rec};
    endfunction

    function automatic logic [31:0] ref_res(input logic [31:0] s, input logic [5:0] k);
        if (k >= 6'd32) return {32{s[31]}};
        return 32'($signed(s) >>> k);
    endfunction

    function automatic logic ref_carry(input logic [31:0] s, input logic [5:0] k);
        logic [31:0] lost;
        if (k >= 6'd32) return s[31];
        lost = s & ((32'd1 << k) - 32'd1);
        return s[31] && (lost != 0);
    endfunction

    function automatic logic [3:0] ref_cond(input logic [31:0] r, input logic s);
        return {r[31], !r[31] && r != 0, r == 0, s};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] s,
                         input logic [31:0] a, input logic f);
        @(negedge clk);
        instr = i; src = s; amt = a; so = f;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        instr = mk_instr(5'd9, 1'b1); src = 32'h8000_0001; amt = 32'd3;
        @(posedge clk); #1;
        chk("R9 reset result", result, 0);
        chk("R9 reset flags", {27'd0, illegal, res_we, carry, carry_we, cond_we}, 0);
        chk("R9 reset cond", {28'd0, cond}, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_examples;
        apply(mk_instr(5'd6, 1'b0), 32'h9000_3000, 32'h24, 1'b0);
        chk("R4 example saturate", result, 32'hFFFF_FFFF);
        chk("R1 dest index", {27'd0, dst}, 6);
        chk("R1 write enables", {30'd0, res_we, carry_we}, 3);
        chk("R7 no cond write", {31'd0, cond_we}, 0);
        apply(mk_instr(5'd6, 1'b1), 32'hB004_3000, 32'h4, 1'b0);
        chk("R3 example shift", result, 32'hFB00_4300);
        chk("R7 example cond", {28'd0, cond}, 32'h8);
        chk("R5 example carry", {31'd0, carry}, 0);
    endtask

    task automatic t_sweep;
        logic [31:0] ops [6] = '{32'h8000_0001, 32'h7FFF_FFFF, 32'hB004_3000,
                                 32'h0000_0001, 32'hFFFF_FFFF, 32'h1234_5678};
        for (int o = 0; o < 6; o++) begin
            for (int k = 0; k < 64; k++) begin
                apply(mk_instr(5'(k), 1'b0), ops[o], 32'(k), 1'b0);
                if (k == 0) chk("R6 zero pass", result, ops[o]);
                else if (k >= 32) chk("R4 saturate", result, ref_res(ops[o], 6'(k)));
                else chk("R3 shift", result, ref_res(ops[o], 6'(k)));
                chk("R5 carry", {31'd0, carry}, {31'd0, ref_carry(ops[o], 6'(k))});
            end
        end
    endtask

    task automatic t_record;
        logic [31:0] vals [4] = '{32'h0000_0000, 32'h0000_0100, 32'h8000_0000, 32'h0000_00F0};
        for (int v = 0; v < 4; v++) begin
            for (int f = 0; f < 2; f++) begin
                apply(mk_instr(5'd2, 1'b1), vals[v], 32'd4, f[0]);
                chk("R7 cond", {28'd0, cond},
                    {28'd0, ref_cond(ref_res(vals[v], 6'd4), f[0])});
                chk("R7 cond we", {31'd0, cond_we}, 1);
            end
        end
    endtask

    task automatic t_illegal;
        logic [31:0] bads [4];
        bads[0] = {6'd30, 5'd1, 5'd2, 5'd3, 10'd792, 1'b1};
        bads[1] = {6'd31, 5'd1, 5'd2, 5'd3, 10'd824, 1'b1};
        bads[2] = {6'd31, 5'd1, 5'd2, 5'd3, 10'd793, 1'b0};
        bads[3] = 32'h0000_0000;
        for (int b = 0; b < 4; b++) begin
            apply(bads[b], 32'hF000_000F, 32'd2, 1'b1);
            chk("R2 illegal flag", {31'd0, illegal}, 1);
            chk("R2 no writes", {29'd0, res_we, carry_we, cond_we}, 0);
            chk("R2 zero data", {result[31:4], result[3:0] | cond, 3'd0, carry}, 0);
        end
        apply(mk_instr(5'd17, 1'b0), 32'd5, 32'd1, 1'b0);
        chk("R1 legal again", {26'd0, illegal, dst}, 17);
    endtask

    task automatic t_high_ignored;
        logic [31:0] his [3] = '{32'hFFFF_FFC0, 32'h8000_0000, 32'h5A5A_5A40};
        for (int h = 0; h < 3; h++) begin
            apply(mk_instr(5'd1, 1'b1), 32'hC000_0003, his[h] | 32'd2, 1'b0);
            chk("R8 high bits result", result, 32'hF000_0000);
            chk("R8 high bits carry", {31'd0, carry}, 1);
            chk("R8 high bits cond", {28'd0, cond}, 32'h8);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                t_reset();
                t_examples();
                t_sweep();
                t_record();
                t_illegal();
                t_high_ignored();
            end
            begin
                repeat (100000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule